// File: doc/BRIEF.md
# SDRAM Command Front End

This block sits right behind the pins of a synchronous DRAM device model. On every rising clock edge it samples the control strobes, clock enable, bank select and address bus. It turns each sample into one decoded operation and presents it one cycle later as a one-hot command, together with the bank, row, column, auto-precharge and precharge-all qualifiers.

The block holds the mode word: burst length, burst order, read latency and write mode. It keeps, for each bank, whether the bank is open and which row is open. It also runs a burst-length countdown for each bank, so that a pending auto-precharge closes the bank at the end of its burst. Operations that break the protocol are passed through with an illegal flag and change no state. These are a mode write while a bank is open, a mode write with a reserved code, a command inside the post-mode-write gap, an activate of an open bank, an access to an idle bank, and a refresh with a bank open.

There is no data stream in this block, so it has no valid/ready pair and no back-pressure. Every pin is a plain control or status signal. Exactly one command is decoded on every clock; deselect and held-low clock enable decode as no-operation.

Top module: `sdram_cmd_front`

## Requirements
- R1: With the clock enable high in this cycle and the one before, chip select low and (row strobe, column strobe, write strobe) equal to LLL give mode write, LHH activate, HLH read, HLL write, LHL precharge, HHL burst stop and LLH auto refresh. HHH, or chip select high, gives no-operation. One-hot bit positions of `cmd_oh`: 0 nop, 1 mode write, 2 activate, 3 read, 4 write, 5 precharge, 6 burst stop, 7 auto refresh, 8 self-refresh entry, 9 power-down/suspend entry, 10 clock-enable exit.
- R2: When the clock enable goes from high to low, the refresh strobe pattern with chip select low decodes as self-refresh entry and any other pattern as power-down/suspend entry. A low-to-high transition decodes as exit. While the clock enable stays low, the decode is no-operation.
- R3: Address bit 10 high on a read or write sets `cmd_autopre`. On a precharge, bit 10 high sets `cmd_pre_all` and closes every bank; bit 10 low closes only the bank on `bank_in`. `cmd_col` is address bits 8..0 and `cmd_bank` is the sampled bank.
- R4: A legal mode write loads burst code from address bits 2..0, interleave from bit 3, latency code from bits 6..4 (`cas_lat` shows the low two bits), and single-write from bit 9. Reset values are burst code 010, sequential order, latency 2 and burst write.
- R5: A mode write is illegal and leaves the mode unchanged if any bank is open, or if any of the following holds: the latency code is not 010 or 011; the burst code is 100, 101 or 110, or is 111 with interleave; any of address bits 7, 8, 10, 11 or the bank select is nonzero.
- R6: In the cycle right after a legal mode write, any command decoded with the clock enable held high other than no-operation is illegal. Two cycles after, commands are accepted again.
- R7: Activating an open bank, or reading or writing an idle bank or a bank with auto-precharge pending, is illegal and changes no bank state. A legal activate opens the bank and stores its row.
- R8: A legal read or write with auto-precharge closes its bank N clocks after the command appears on the outputs. N is 1, 2, 4 or 8 for burst codes 000 to 011, 512 for 111, and 1 for a write in single-write mode. A precharge cancels the countdown.
- R9: On a read or write, `cmd_row` shows the row stored for that bank. On other commands it shows the address bus.
- R10: Auto refresh or self-refresh entry while any bank is open is illegal.
- R11: All outputs are registered one cycle after the sampling edge. Under reset the command is no-operation and every bank is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable pin |
| chip_sel_n | input | 1 | Chip select, active low |
| rstrobe_n | input | 1 | Row strobe, active low |
| cstrobe_n | input | 1 | Column strobe, active low |
| wstrobe_n | input | 1 | Write strobe, active low |
| bank_in | input | 2 | Bank select |
| addr_in | input | 12 | Address / op-code bus |
| cmd_oh | output | 11 | One-hot decoded command |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | 12 | Row (stored row on read/write) |
| cmd_col | output | 9 | Column |
| cmd_autopre | output | 1 | Auto-precharge requested |
| cmd_pre_all | output | 1 | Precharge targets all banks |
| cmd_illegal | output | 1 | Command violated protocol, ignored |
| cas_lat | output | 2 | Read latency in clocks |
| burst_code | output | 3 | Stored burst length code |
| burst_interleave | output | 1 | Interleaved burst order |
| write_single | output | 1 | Single-write mode |
| bank_open | output | 4 | Per-bank open flag |

## Verification
Directed sequences cover each strobe pattern with the clock enable steady, and each clock-enable edge with the refresh pattern and with other patterns, which separates self-refresh entry from power-down entry and exit. Mode writes are tried with each reserved field in turn and with banks open, and a command is placed in the gap right after a mode write, so the legality conditions cannot be confused with one another. Auto-precharge reads and writes under burst lengths 8, 1 (single write) and full page confirm the closing cycle. A long run of random strobe patterns, banks and addresses then mixes every ordering against a behavioural model that is checked on every clock.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int NCMD = 11;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_MRS  = 4'd1,
    C_ACT  = 4'd2,
    C_RD   = 4'd3,
    C_WR   = 4'd4,
    C_PRE  = 4'd5,
    C_BST  = 4'd6,
    C_REF  = 4'd7,
    C_SREF = 4'd8,
    C_PDN  = 4'd9,
    C_EXIT = 4'd10
  } cmd_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       ws;
  } mode_t;

  localparam mode_t MODE_RST = '{bl: 3'b010, bt: 1'b0, cl: 3'b010, ws: 1'b0};
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_now,
  input  logic cs_n,
  input  logic rs_n,
  input  logic cs2_n,
  input  logic ws_n,
  output cmd_e cmd
);
  always_comb begin
    if (!cke_prev) begin
      cmd = cke_now ? C_EXIT : C_NOP;
    end else if (!cke_now) begin
      cmd = (!cs_n && !rs_n && !cs2_n && ws_n) ? C_SREF : C_PDN;
    end else if (cs_n) begin
      cmd = C_NOP;
    end else begin
      unique case ({rs_n, cs2_n, ws_n})
        3'b000:  cmd = C_MRS;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b110:  cmd = C_BST;
        3'b001:  cmd = C_REF;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_mode.sv
module sdcmd_mode
  import sdcmd_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [BA_W-1:0]   bank,
  output logic              word_ok,
  output mode_t             mode
);
  logic bl_ok, cl_ok, zero_ok;

  always_comb begin
    unique case (word[2:0])
      3'b100, 3'b101, 3'b110: bl_ok = 1'b0;
      3'b111:                 bl_ok = !word[3];
      default:                bl_ok = 1'b1;
    endcase
    cl_ok   = (word[6:4] == 3'b010) || (word[6:4] == 3'b011);
    zero_ok = (word[8:7] == 2'b00) && (word[WORD_W-1:10] == '0) && (bank == '0);
    word_ok = bl_ok && cl_ok && zero_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RST;
    end else if (load) begin
      mode.bl <= word[2:0];
      mode.bt <= word[3];
      mode.cl <= word[6:4];
      mode.ws <= word[9];
    end
  end
endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks #(
  parameter int NBANK = 4,
  parameter int ROW_W = 12,
  parameter int CNT_W = 10,
  localparam int BA_W = $clog2(NBANK)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act_en,
  input  logic                         pre_en,
  input  logic                         pre_all,
  input  logic                         ap_en,
  input  logic [BA_W-1:0]              bank,
  input  logic [ROW_W-1:0]             row_in,
  input  logic [CNT_W-1:0]             beats,
  output logic [NBANK-1:0]             open_q,
  output logic [NBANK-1:0]             pend,
  output logic [NBANK-1:0][ROW_W-1:0]  rows
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             sel;
    logic [CNT_W-1:0] cnt;

    assign sel     = (bank == BA_W'(b));
    assign pend[b] = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        rows[b]   <= '0;
        cnt       <= '0;
      end else if (act_en && sel) begin
        open_q[b] <= 1'b1;
        rows[b]   <= row_in;
        cnt       <= '0;
      end else if (pre_en && (pre_all || sel)) begin
        open_q[b] <= 1'b0;
        cnt       <= '0;
      end else if (ap_en && sel) begin
        cnt <= beats;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) open_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int NBANK  = 4,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              chip_sel_n,
  input  logic              rstrobe_n,
  input  logic              cstrobe_n,
  input  logic              wstrobe_n,
  input  logic [BA_W-1:0]   bank_in,
  input  logic [ROW_W-1:0]  addr_in,
  output logic [NCMD-1:0]   cmd_oh,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_autopre,
  output logic              cmd_pre_all,
  output logic              cmd_illegal,
  output logic [1:0]        cas_lat,
  output logic [2:0]        burst_code,
  output logic              burst_interleave,
  output logic              write_single,
  output logic [NBANK-1:0]  bank_open
);
  localparam int CNT_W = COL_W + 1;

  logic  cke_prev, mrd_gap;
  cmd_e  cmd;
  mode_t mode;
  logic  word_ok, ill, is_rw;
  logic  [CNT_W-1:0] beats;
  logic  [NBANK-1:0] pend;
  logic  [NBANK-1:0][ROW_W-1:0] rows;

  sdcmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke_now  (clk_en),
    .cs_n     (chip_sel_n),
    .rs_n     (rstrobe_n),
    .cs2_n    (cstrobe_n),
    .ws_n     (wstrobe_n),
    .cmd      (cmd)
  );

  assign is_rw = (cmd == C_RD) || (cmd == C_WR);

  always_comb begin
    unique case (cmd)
      C_MRS:        ill = mrd_gap || (|bank_open) || !word_ok;
      C_ACT:        ill = mrd_gap || bank_open[bank_in];
      C_RD, C_WR:   ill = mrd_gap || !bank_open[bank_in] || pend[bank_in];
      C_PRE, C_BST: ill = mrd_gap;
      C_REF:        ill = mrd_gap || (|bank_open);
      C_SREF:       ill = |bank_open;
      default:      ill = 1'b0;
    endcase
  end

  always_comb begin
    if (cmd == C_WR && mode.ws) beats = CNT_W'(1);
    else if (mode.bl == 3'b111)  beats = CNT_W'(1) << COL_W;
    else                         beats = CNT_W'(1) << mode.bl[1:0];
  end

  sdcmd_mode #(.WORD_W(ROW_W), .BA_W(BA_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd == C_MRS && !ill),
    .word    (addr_in),
    .bank    (bank_in),
    .word_ok (word_ok),
    .mode    (mode)
  );

  sdcmd_banks #(.NBANK(NBANK), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_en  (cmd == C_ACT && !ill),
    .pre_en  (cmd == C_PRE && !ill),
    .pre_all (addr_in[AP_BIT]),
    .ap_en   (is_rw && !ill && addr_in[AP_BIT]),
    .bank    (bank_in),
    .row_in  (addr_in),
    .beats   (beats),
    .open_q  (bank_open),
    .pend    (pend),
    .rows    (rows)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev    <= 1'b1;
      mrd_gap     <= 1'b0;
      cmd_oh      <= NCMD'(1);
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_autopre <= 1'b0;
      cmd_pre_all <= 1'b0;
      cmd_illegal <= 1'b0;
    end else begin
      cke_prev    <= clk_en;
      mrd_gap     <= (cmd == C_MRS) && !ill;
      cmd_oh      <= NCMD'(1) << cmd;
      cmd_bank    <= bank_in;
      cmd_row     <= is_rw ? rows[bank_in] : addr_in;
      cmd_col     <= addr_in[COL_W-1:0];
      cmd_autopre <= is_rw && addr_in[AP_BIT];
      cmd_pre_all <= (cmd == C_PRE) && addr_in[AP_BIT];
      cmd_illegal <= ill;
    end
  end

  assign cas_lat          = mode.cl[1:0];
  assign burst_code       = mode.bl;
  assign burst_interleave = mode.bt;
  assign write_single     = mode.ws;
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk
  import sdcmd_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCMD-1:0]  cmd_oh,
  input logic [BA_W-1:0]  cmd_bank,
  input logic             cmd_autopre,
  input logic             cmd_illegal,
  input logic [1:0]       cas_lat,
  input logic [2:0]       burst_code,
  input logic             burst_interleave,
  input logic             write_single,
  input logic [NBANK-1:0] bank_open
);
  localparam logic [NCMD-1:0] GATED = NCMD'(8'hFE);

  logic [NBANK-1:0] prev_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_open <= '0;
    else        prev_open <= bank_open;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cmd_oh));

  a_r4_latency_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));

  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_oh[C_MRS] && !cmd_illegal) |->
      $stable({cas_lat, burst_code, burst_interleave, write_single}));

  a_r5_mrs_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[C_MRS] && (|prev_open) |-> cmd_illegal);

  a_r6_mrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[C_MRS] && !cmd_illegal |=> cmd_illegal || ((cmd_oh & GATED) == '0));

  a_r7_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[C_ACT] && !cmd_illegal |-> !prev_open[cmd_bank] && bank_open[cmd_bank]);

  a_r7_rw_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oh[C_RD] || cmd_oh[C_WR]) && !cmd_illegal |-> prev_open[cmd_bank]);

  a_r10_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oh[C_REF] || cmd_oh[C_SREF]) && (|prev_open) |-> cmd_illegal);

  a_r3_ap_rw_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_autopre |-> cmd_oh[C_RD] || cmd_oh[C_WR]);
endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(.NBANK(NBANK), .BA_W(BA_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cmd_oh           (cmd_oh),
  .cmd_bank         (cmd_bank),
  .cmd_autopre      (cmd_autopre),
  .cmd_illegal      (cmd_illegal),
  .cas_lat          (cas_lat),
  .burst_code       (burst_code),
  .burst_interleave (burst_interleave),
  .write_single     (write_single),
  .bank_open        (bank_open)
);

// File: tb/sdram_cmd_front_test.sv
module sdram_cmd_front_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b1, chip_sel_n = 1'b1, rstrobe_n = 1'b1, cstrobe_n = 1'b1, wstrobe_n = 1'b1;
  logic [1:0]  bank_in = '0;
  logic [11:0] addr_in = '0;
  logic [10:0] cmd_oh;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_row;
  logic [8:0]  cmd_col;
  logic cmd_autopre, cmd_pre_all, cmd_illegal;
  logic [1:0] cas_lat;
  logic [2:0] burst_code;
  logic burst_interleave, write_single;
  logic [3:0] bank_open;

  sdram_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
    .rstrobe_n(rstrobe_n), .cstrobe_n(cstrobe_n), .wstrobe_n(wstrobe_n),
    .bank_in(bank_in), .addr_in(addr_in), .cmd_oh(cmd_oh), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
    .cmd_pre_all(cmd_pre_all), .cmd_illegal(cmd_illegal), .cas_lat(cas_lat),
    .burst_code(burst_code), .burst_interleave(burst_interleave),
    .write_single(write_single), .bank_open(bank_open)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string phase = "R11 reset";

  // behavioural reference state
  int  m_cmd = 0, m_bank = 0, m_row = 0, m_col = 0;
  bit  m_ap = 0, m_all = 0, m_ill = 0;
  int  m_bl = 2, m_cl = 2;
  bit  m_bt = 0, m_ws = 0, m_gap = 0, m_ckep = 1;
  bit  m_open[4];
  int  m_orow[4];
  int  m_cnt[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_bank = 0; m_row = 0; m_col = 0; m_ap = 0; m_all = 0; m_ill = 0;
      m_bl = 2; m_cl = 2; m_bt = 0; m_ws = 0; m_gap = 0; m_ckep = 1;
      for (int k = 0; k < 4; k++) begin m_open[k] = 0; m_orow[k] = 0; m_cnt[k] = 0; end
    end else begin
      int c, b, beats, anyopen;
      bit ill, word_ok, rw;
      b = int'(bank_in);
      if (!m_ckep) c = clk_en ? 10 : 0;
      else if (!clk_en) c = (!chip_sel_n && !rstrobe_n && !cstrobe_n && wstrobe_n) ? 8 : 9;
      else if (chip_sel_n) c = 0;
      else begin
        case ({rstrobe_n, cstrobe_n, wstrobe_n})
          3'b000: c = 1; 3'b011: c = 2; 3'b101: c = 3; 3'b100: c = 4;
          3'b010: c = 5; 3'b110: c = 6; 3'b001: c = 7; default: c = 0;
        endcase
      end
      anyopen = 0;
      for (int k = 0; k < 4; k++) if (m_open[k]) anyopen = 1;
      word_ok = (addr_in[6:4] == 3'd2 || addr_in[6:4] == 3'd3) &&
                (addr_in[2:0] < 3'd4 || (addr_in[2:0] == 3'd7 && !addr_in[3])) &&
                !addr_in[7] && !addr_in[8] && !addr_in[10] && !addr_in[11] && bank_in == 2'd0;
      rw = (c == 3 || c == 4);
      ill = 0;
      if (c == 1) ill = m_gap || anyopen != 0 || !word_ok;
      if (c == 2) ill = m_gap || m_open[b];
      if (rw)     ill = m_gap || !m_open[b] || m_cnt[b] != 0;
      if (c == 5 || c == 6) ill = m_gap;
      if (c == 7) ill = m_gap || anyopen != 0;
      if (c == 8) ill = anyopen != 0;
      if (c == 4 && m_ws) beats = 1;
      else if (m_bl == 7) beats = 512;
      else beats = 1 << m_bl;
      m_cmd = c; m_bank = b; m_col = int'(addr_in[8:0]); m_ill = ill;
      m_row = rw ? m_orow[b] : int'(addr_in);
      m_ap = rw && addr_in[10];
      m_all = (c == 5) && addr_in[10];
      for (int k = 0; k < 4; k++) begin
        if (c == 2 && !ill && k == b) begin m_open[k] = 1; m_orow[k] = int'(addr_in); m_cnt[k] = 0; end
        else if (c == 5 && !ill && (addr_in[10] || k == b)) begin m_open[k] = 0; m_cnt[k] = 0; end
        else if (rw && !ill && k == b && addr_in[10]) m_cnt[k] = beats;
        else if (m_cnt[k] > 0) begin m_cnt[k]--; if (m_cnt[k] == 0) m_open[k] = 0; end
      end
      if (c == 1 && !ill) begin
        m_bl = int'(addr_in[2:0]); m_bt = addr_in[3]; m_cl = int'(addr_in[6:4]); m_ws = addr_in[9];
      end
      m_gap = (c == 1) && !ill;
      m_ckep = clk_en;
    end
  end

  task automatic cmp(string req, string field, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: got 0x%0h expected 0x%0h at %0t", req, phase, field, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int ob;
    ob = 0;
    for (int k = 0; k < 4; k++) if (m_open[k]) ob |= (1 << k);
    cmp("R1", "cmd_oh", int'(cmd_oh), 1 << m_cmd);
    cmp("R3", "cmd_bank", int'(cmd_bank), m_bank);
    cmp("R9", "cmd_row", int'(cmd_row), m_row);
    cmp("R3", "cmd_col", int'(cmd_col), m_col);
    cmp("R3", "cmd_autopre", int'(cmd_autopre), int'(m_ap));
    cmp("R3", "cmd_pre_all", int'(cmd_pre_all), int'(m_all));
    cmp("R7", "cmd_illegal", int'(cmd_illegal), int'(m_ill));
    cmp("R4", "cas_lat", int'(cas_lat), m_cl & 3);
    cmp("R4", "burst_code", int'(burst_code), m_bl);
    cmp("R4", "burst_interleave", int'(burst_interleave), int'(m_bt));
    cmp("R4", "write_single", int'(write_single), int'(m_ws));
    cmp("R8", "bank_open", int'(bank_open), ob);
  end

  task automatic pins(bit cs, bit r, bit c, bit w, bit ck, int b, int a);
    @(posedge clk); #1;
    chip_sel_n = cs; rstrobe_n = r; cstrobe_n = c; wstrobe_n = w;
    clk_en = ck; bank_in = 2'(b); addr_in = 12'(a);
  endtask
  task automatic nop(int n);
    for (int i = 0; i < n; i++) pins(1, 1, 1, 1, 1, 0, 0);
  endtask
  task automatic mrs(int w, int b = 0); pins(0, 0, 0, 0, 1, b, w); endtask
  task automatic act(int b, int r); pins(0, 0, 1, 1, 1, b, r); endtask
  task automatic rd(int b, int col, bit ap); pins(0, 1, 0, 1, 1, b, col | (ap << 10)); endtask
  task automatic wr(int b, int col, bit ap); pins(0, 1, 0, 0, 1, b, col | (ap << 10)); endtask
  task automatic pre(int b, bit all); pins(0, 0, 1, 0, 1, b, all << 10); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R1 nop and deselect"; nop(2); pins(0, 1, 1, 1, 1, 0, 0);
    phase = "R4 mode write BL8 CL3"; mrs(12'h033);
    phase = "R6 gap after mode write"; act(0, 12'h5A5);
    nop(1);
    phase = "R7 activate"; act(0, 12'h5A5);
    phase = "R7 activate open bank"; act(0, 12'h111);
    phase = "R7 access idle bank"; rd(1, 5, 0); wr(2, 6, 0);
    phase = "R5 mode write with bank open"; mrs(12'h022);
    phase = "R9 read row from store"; rd(0, 12'h1F3, 0); pins(0, 1, 1, 0, 1, 0, 0);
    phase = "R10 refresh with bank open"; pins(0, 0, 0, 1, 1, 0, 0);
    phase = "R8 read auto-precharge BL8"; rd(0, 3, 1);
    rd(0, 4, 0); nop(10);
    phase = "R3 precharge all and single"; act(1, 12'h0AB); act(3, 12'hF00);
    pre(3, 0); act(3, 12'h00F); pre(0, 1); nop(1);
    phase = "R5 reserved latency"; mrs(12'h013); nop(1);
    phase = "R5 reserved burst"; mrs(12'h024); nop(1);
    phase = "R5 full page interleave"; mrs(12'h02F); nop(1);
    phase = "R5 nonzero upper bits"; mrs(12'h0A2); mrs(12'h422); mrs(12'h022, 1); nop(1);
    phase = "R4 single write interleave BL4"; mrs(12'h22A); nop(1);
    phase = "R8 single write auto-precharge"; act(2, 12'h321); wr(2, 9, 1); nop(3);
    phase = "R8 full page auto-precharge"; mrs(12'h027); nop(1);
    act(1, 12'h777); rd(1, 0, 1); wr(1, 0, 0); nop(515);
    act(2, 12'h001); rd(2, 1, 1); nop(4); pre(2, 0); nop(2);
    phase = "R10 refresh idle"; pins(0, 0, 0, 1, 1, 0, 0);
    phase = "R2 self refresh entry and exit"; pins(0, 0, 0, 1, 0, 0, 0);
    pins(0, 1, 0, 1, 0, 0, 0); pins(1, 1, 1, 1, 0, 0, 0); pins(1, 1, 1, 1, 1, 0, 0);
    phase = "R2 power down with bank open"; act(0, 12'h0C3); pins(1, 1, 1, 1, 0, 0, 0);
    pins(1, 1, 1, 1, 0, 0, 0); pins(0, 1, 1, 1, 1, 0, 0);
    phase = "R10 self refresh with bank open"; pins(0, 0, 0, 1, 0, 0, 0); pins(1, 1, 1, 1, 1, 0, 0);
    pre(0, 1); nop(1);
    phase = "R1 random mix";
    for (int i = 0; i < 4000; i++) begin
      int a;
      a = int'($urandom_range(0, 4095));
      if ($urandom_range(0, 3) == 0) a = (a & 12'h400) | ($urandom_range(2, 3) << 4) | $urandom_range(0, 3) | (($urandom_range(0, 1)) << 9);
      pins($urandom_range(0, 7) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 19) != 0, int'($urandom_range(0, 3)), a);
    end
    nop(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule